// File: doc/BRIEF.md
# Receive Byte Queue with Fill Trigger and Idle Timeout

This block buffers bytes coming out of a serial receiver's shift register until the processor collects them. Each incoming byte arrives with a one-cycle valid strobe and is appended to a 16-deep queue. The processor reads the oldest byte from a show-ahead data port and removes it with a read strobe. The current occupancy is always visible on a level output.

Two interrupt lines help software decide when to service the queue. The data line rises once the occupancy reaches a threshold chosen by a 2-bit code. The timeout line catches a short tail of bytes that stays below that threshold. It fires after four character-time ticks pass with no push and no pop while the queue holds data. A sticky overrun flag records any byte that was lost because the queue was full. Software clears the flag with a dedicated strobe.

Top module: `rx_fifo_trigtimer`

## Requirements
- R1: Bytes leave in the order they were accepted. `rd_data` always shows the oldest stored byte and reads 0 while the queue is empty.
- R2: The queue holds at most 16 bytes and `fill_level` reports the count from 0 to 16. A byte offered while the level is 16 is discarded, and the level and stored contents stay unchanged.
- R3: A byte offered while the level is 16 sets `overrun` on the next cycle, even if a read happens in that same cycle. `overrun` stays set until `ovr_clear` is pulsed. If a new overrun and a clear happen in the same cycle, the flag stays set.
- R4: `trig_sel` selects the threshold: code 0 means 1 byte, 1 means 4, 2 means 8 and 3 means 14. `data_irq` is high exactly when `irq_en` is high and `fill_level` is at or above the selected threshold.
- R5: `timeout_irq` rises when `irq_en` is high, the level is at least 1, and four `char_tick` pulses have occurred since the last push or pop. A tick in the same cycle as a push or pop does not count. The timeout never fires while the queue is empty.
- R6: `timeout_irq` drops in the cycle after an accepted push or pop.
- R7: A read strobe on an empty queue has no effect, and the level stays 0.
- R8: With `irq_en` low, both `data_irq` and `timeout_irq` are low.
- R9: After reset, the level is 0, and `overrun`, `data_irq` and `timeout_irq` are all low.
- R10: A push and a pop in the same cycle with the level between 1 and 15 leave the level unchanged and preserve the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_byte | input | 8 | Byte from the receive shift register |
| rx_valid | input | 1 | One-cycle strobe, `rx_byte` is valid |
| rd_strobe | input | 1 | Processor read, removes the oldest byte |
| trig_sel | input | 2 | Threshold code for the data interrupt |
| irq_en | input | 1 | Enables both interrupt lines |
| char_tick | input | 1 | One pulse per character time |
| ovr_clear | input | 1 | Clears the overrun flag |
| rd_data | output | 8 | Oldest stored byte (0 when empty) |
| fill_level | output | 5 | Number of stored bytes |
| data_irq | output | 1 | Threshold-reached interrupt |
| timeout_irq | output | 1 | Idle-with-data interrupt |
| overrun | output | 1 | Sticky lost-byte flag |

## Verification
The assertions assume that `rx_valid`, `rd_strobe`, `char_tick` and `ovr_clear` are single-cycle-per-event strobes sampled at the clock edge. They also assume that `char_tick` is the only thing that can advance the idle count. The stimulus changes every input at the falling edge and holds each strobe for exactly one cycle. It also places ticks either alone or together with a push, so the idle count sees both the counted and the discarded case. Overflow is reached only through real pushes past 16 entries, including cases combined with a read or with a clear.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   // Threshold selector codes for the data interrupt
   typedef enum logic [1:0] {
      TRIG_SEL_A = 2'd0,
      TRIG_SEL_B = 2'd1,
      TRIG_SEL_C = 2'd2,
      TRIG_SEL_D = 2'd3
   } trig_code_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int unsigned DATA_W          = 8,
   parameter int unsigned DEPTH           = 16,
   parameter bit          ZERO_WHEN_EMPTY = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push_req,
   input  logic [DATA_W-1:0]          data_in,
   input  logic                       pop_req,
   output logic [DATA_W-1:0]          head,
   output logic [$clog2(DEPTH+1)-1:0] level,
   output logic                       full,
   output logic                       empty,
   output logic                       push_ok,
   output logic                       pop_ok
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned LW = $clog2(DEPTH + 1);

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("rxq_store: DEPTH must be a power of two");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr;

   assign full    = (level == LW'(DEPTH));
   assign empty   = (level == '0);
   assign push_ok = push_req && !full;
   assign pop_ok  = pop_req && !empty;

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= data_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + AW'(1);
         if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
         case ({push_ok, pop_ok})
            2'b10:   level <= level + LW'(1);
            2'b01:   level <= level - LW'(1);
            default: level <= level;
         endcase
      end
   end

   if (ZERO_WHEN_EMPTY) begin : g_masked_head
      assign head = empty ? '0 : mem[rd_ptr];
   end else begin : g_raw_head
      assign head = mem[rd_ptr];
   end

   // R2
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push_req && !pop_req) |=> (level == LW'(DEPTH)) && $stable(head));

   // R10
   push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_ok && pop_ok) |=> $stable(level));

   // R7
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop_req && !push_req) |=> empty);
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
   parameter int unsigned LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic touch,
   input  logic tick,
   output logic expired
);
   localparam int unsigned CW = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("rxq_idle_timer: LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt <= '0;
      else if (!active || touch)          cnt <= '0;
      else if (tick && cnt != CW'(LIMIT)) cnt <= cnt + CW'(1);
   end

   assign expired = (cnt == CW'(LIMIT));

   // R5
   expire_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(expired) |-> $past(tick) && $past(active));

   // R6
   touch_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      touch |=> !expired);
endmodule

// File: rtl/rx_fifo_trigtimer.sv
module rx_fifo_trigtimer #(
   parameter int unsigned DATA_W          = 8,
   parameter int unsigned DEPTH           = 16,
   parameter int unsigned IDLE_CHARS      = 4,
   parameter int unsigned TRIG_LVL_A      = 1,
   parameter int unsigned TRIG_LVL_B      = 4,
   parameter int unsigned TRIG_LVL_C      = 8,
   parameter int unsigned TRIG_LVL_D      = 14,
   parameter bit          ZERO_WHEN_EMPTY = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [DATA_W-1:0]          rx_byte,
   input  logic                       rx_valid,
   input  logic                       rd_strobe,
   input  logic [1:0]                 trig_sel,
   input  logic                       irq_en,
   input  logic                       char_tick,
   input  logic                       ovr_clear,
   output logic [DATA_W-1:0]          rd_data,
   output logic [$clog2(DEPTH+1)-1:0] fill_level,
   output logic                       data_irq,
   output logic                       timeout_irq,
   output logic                       overrun
);
   import rxq_pkg::*;

   localparam int unsigned LW = $clog2(DEPTH + 1);

   if (TRIG_LVL_A < 1 || TRIG_LVL_A > DEPTH || TRIG_LVL_B < 1 || TRIG_LVL_B > DEPTH ||
       TRIG_LVL_C < 1 || TRIG_LVL_C > DEPTH || TRIG_LVL_D < 1 || TRIG_LVL_D > DEPTH)
   begin : g_bad_trig
      $error("rx_fifo_trigtimer: trigger levels must lie in 1..DEPTH");
   end

   logic          full, empty, push_ok, pop_ok, idle_expired;
   logic [LW-1:0] trig_lvl;

   rxq_store #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .ZERO_WHEN_EMPTY(ZERO_WHEN_EMPTY)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .push_req(rx_valid), .data_in(rx_byte), .pop_req(rd_strobe),
      .head(rd_data), .level(fill_level),
      .full(full), .empty(empty), .push_ok(push_ok), .pop_ok(pop_ok)
   );

   rxq_idle_timer #(.LIMIT(IDLE_CHARS)) u_idle (
      .clk(clk), .rst_n(rst_n),
      .active(!empty), .touch(push_ok || pop_ok), .tick(char_tick),
      .expired(idle_expired)
   );

   always_comb begin
      case (trig_code_e'(trig_sel))
         TRIG_SEL_A: trig_lvl = LW'(TRIG_LVL_A);
         TRIG_SEL_B: trig_lvl = LW'(TRIG_LVL_B);
         TRIG_SEL_C: trig_lvl = LW'(TRIG_LVL_C);
         default:    trig_lvl = LW'(TRIG_LVL_D);
      endcase
   end

   assign data_irq    = irq_en && (fill_level >= trig_lvl);
   assign timeout_irq = irq_en && idle_expired && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 overrun <= 1'b0;
      else if (rx_valid && full)  overrun <= 1'b1;
      else if (ovr_clear)         overrun <= 1'b0;
   end

   // R3
   overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && full) |=> overrun);

   // R3
   overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !ovr_clear) |=> overrun);

   // R4
   data_irq_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_irq |-> (fill_level != '0));

   // R5
   timeout_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_irq |-> (fill_level != '0));
endmodule

// File: tb/tb_rx_fifo_trigtimer.sv
module tb_rx_fifo_trigtimer;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] rx_byte = '0;
   logic       rx_valid = 1'b0, rd_strobe = 1'b0, irq_en = 1'b0;
   logic       char_tick = 1'b0, ovr_clear = 1'b0;
   logic [1:0] trig_sel = 2'd0;
   logic [7:0] rd_data;
   logic [4:0] fill_level;
   logic       data_irq, timeout_irq, overrun;

   int checks = 0;
   int fails  = 0;
   logic [7:0] sb [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_fifo_trigtimer dut (
      .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
      .rd_strobe(rd_strobe), .trig_sel(trig_sel), .irq_en(irq_en),
      .char_tick(char_tick), .ovr_clear(ovr_clear), .rd_data(rd_data),
      .fill_level(fill_level), .data_irq(data_irq), .timeout_irq(timeout_irq),
      .overrun(overrun)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Driver: offers a byte; the scoreboard records it only if room exists
   task automatic push_byte(input logic [7:0] b);
      if (sb.size() < 16) sb.push_back(b);
      rx_byte = b; rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   // Monitor: compares the head with the scoreboard, then removes it
   task automatic pop_byte(input string tag);
      chk(tag, rd_data, sb[0]);
      void'(sb.pop_front());
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
   endtask

   task automatic tick_n(input int n);
      for (int i = 0; i < n; i++) begin
         char_tick = 1'b1;
         @(negedge clk);
         char_tick = 1'b0;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk("R9 level", fill_level, 0);
      chk("R9 overrun", overrun, 0);
      chk("R9 data_irq", data_irq, 0);
      chk("R9 timeout_irq", timeout_irq, 0);
      chk("R1 empty data", rd_data, 0);

      // R4 threshold 1
      irq_en = 1'b1; trig_sel = 2'd0;
      push_byte(8'hA1);
      chk("R4 code0 irq", data_irq, 1);
      pop_byte("R1 head");
      chk("R4 below", data_irq, 0);

      // R7 read of empty queue
      rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
      chk("R7 level", fill_level, 0);

      // R4 threshold 4
      trig_sel = 2'd1;
      for (int i = 0; i < 3; i++) push_byte(8'h10 + 8'(i));
      chk("R4 code1 at 3", data_irq, 0);
      push_byte(8'h13);
      chk("R4 code1 at 4", data_irq, 1);

      // R5 idle timeout
      tick_n(3);
      chk("R5 three ticks", timeout_irq, 0);
      tick_n(1);
      chk("R5 four ticks", timeout_irq, 1);

      // R8 gating
      irq_en = 1'b0; #1;
      chk("R8 data", data_irq, 0);
      chk("R8 timeout", timeout_irq, 0);
      irq_en = 1'b1; #1;

      // R6 clears on push and on pop
      push_byte(8'h14);
      chk("R6 push clears", timeout_irq, 0);
      tick_n(4);
      chk("R5 rearm", timeout_irq, 1);
      pop_byte("R1 head");
      chk("R6 pop clears", timeout_irq, 0);

      // R5 tick coinciding with push is not counted
      tick_n(3);
      rx_byte = 8'h15; rx_valid = 1'b1; char_tick = 1'b1; sb.push_back(8'h15);
      @(negedge clk);
      rx_valid = 1'b0; char_tick = 1'b0;
      tick_n(3);
      chk("R5 coincident tick", timeout_irq, 0);
      tick_n(1);
      chk("R5 after four", timeout_irq, 1);

      // R10 push and pop together
      chk("R1 head before", rd_data, sb[0]);
      void'(sb.pop_front()); sb.push_back(8'h16);
      rx_byte = 8'h16; rx_valid = 1'b1; rd_strobe = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0; rd_strobe = 1'b0;
      chk("R10 level", fill_level, 5);

      // drain with order checks
      while (sb.size() > 0) pop_byte("R1 order");
      chk("R1 empty level", fill_level, 0);
      tick_n(5);
      chk("R5 empty no timeout", timeout_irq, 0);

      // R4 thresholds 8 and 14
      trig_sel = 2'd2;
      for (int i = 0; i < 7; i++) push_byte(8'h20 + 8'(i));
      chk("R4 code2 at 7", data_irq, 0);
      push_byte(8'h27);
      chk("R4 code2 at 8", data_irq, 1);
      trig_sel = 2'd3; #1;
      chk("R4 code3 at 8", data_irq, 0);
      for (int i = 0; i < 6; i++) push_byte(8'h28 + 8'(i));
      chk("R4 code3 at 14", data_irq, 1);
      pop_byte("R1 head");
      chk("R4 code3 at 13", data_irq, 0);

      // R2 and R3 fill and overflow
      for (int i = 0; i < 3; i++) push_byte(8'h30 + 8'(i));
      chk("R2 full level", fill_level, 16);
      chk("R3 no overrun yet", overrun, 0);
      push_byte(8'hEE);
      chk("R2 level held", fill_level, 16);
      chk("R3 overrun set", overrun, 1);
      tick_n(1);
      chk("R3 sticky", overrun, 1);
      ovr_clear = 1'b1; @(negedge clk); ovr_clear = 1'b0;
      chk("R3 cleared", overrun, 0);
      rx_byte = 8'hEF; rx_valid = 1'b1; ovr_clear = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0; ovr_clear = 1'b0;
      chk("R3 set beats clear", overrun, 1);
      ovr_clear = 1'b1; @(negedge clk); ovr_clear = 1'b0;
      chk("R1 head at full", rd_data, sb[0]);
      void'(sb.pop_front());
      rx_byte = 8'hF0; rx_valid = 1'b1; rd_strobe = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0; rd_strobe = 1'b0;
      chk("R3 full push with read level", fill_level, 15);
      chk("R3 full push with read flag", overrun, 1);

      while (sb.size() > 0) pop_byte("R2 rejected bytes absent");
      chk("R2 drained", fill_level, 0);
      chk("R1 empty again", rd_data, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule